// File: doc/BRIEF.md
# Level-2 Lookup Decision Unit

This unit makes the final level-2 accept decision for an event. Each event arrives as a one-cycle strobe with three fields: a 4-bit trigger-class code computed upstream, a 6-bit vector of level-1 sector hits, and a 6-bit vector of tracking-chamber sector hits. The code selects one of sixteen programmable entries, so every code value has an entry of its own. This includes combined codes, where more than one upstream class bit is set.

Each entry holds a 2-bit mode and a 6-bit sector enable mask. The mode makes the entry always pass, always fail, or evaluate a sector-matched coincidence. A coincidence means that some enabled sector shows a hit in both the level-1 vector and the tracking vector. A registered accept pulse follows every strobe that evaluates true.

Accepted events are also counted per code in 32-bit counters. Software or a monitoring agent drains a counter with a single read-and-clear operation, so no accept is lost between the read and the clear. A typical setup gives codes 1, 2, 4 and 8 the coincidence mode and leaves every other code failing.

Top module: `l2_lookup_decider`

## Requirements
- R1: After reset every entry is a forced fail, every counter is zero, `accept` is low and `cnt_rdata` is zero.
- R2: Mode encoding is 2'b00 fail, 2'b01 pass and 2'b10 coincidence. The value 2'b11 behaves as fail. A pass entry accepts whatever the sector vectors hold.
- R3: A coincidence entry accepts when some bit i satisfies `l1_sec[i] & trk_sec[i] & mask[i]`. Bit i stands for sector i+1, so bit 5 is sector 6. A sector whose mask bit is 0 never contributes.
- R4: `accept` is high in the cycle after a strobe (`in_valid` high) whose selected entry evaluates true, and for exactly one cycle per such strobe. With `in_valid` low, `accept` stays low.
- R5: The full 4-bit `in_code` selects the entry. A combined code such as 4'd3 uses its own entry, independent of the entries for 4'd1 and 4'd2.
- R6: A write (`cfg_we`) sets the mode and mask of entry `cfg_code` at the clock edge. A strobe in the same cycle as the write uses the previous contents of the entry, and strobes in later cycles use the new contents.
- R7: Each code has a 32-bit counter that adds one for every accepted strobe carrying that code.
- R8: A read (`cnt_rd`) loads the counter of `cnt_code` into `cnt_rdata` in the next cycle and clears that counter. If an accept for the same code happens in the same cycle, the counter reads back 1 afterwards.
- R9: `cnt_rdata` keeps its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Event strobe |
| in_code | input | 4 | Trigger-class code selecting the entry |
| in_l1_sec | input | 6 | Level-1 sector hits, bit 0 = sector 1 |
| in_trk_sec | input | 6 | Tracking-chamber sector hits, bit 0 = sector 1 |
| cfg_we | input | 1 | Entry write enable |
| cfg_code | input | 4 | Entry to write |
| cfg_mode | input | 2 | Mode to write (00 fail, 01 pass, 10 coincidence) |
| cfg_mask | input | 6 | Sector enable mask to write |
| cnt_rd | input | 1 | Read-and-clear strobe for a counter |
| cnt_code | input | 4 | Counter to read |
| cnt_rdata | output | 32 | Counter value captured by the last read |
| accept | output | 1 | Registered one-cycle accept pulse |

## Verification
The coincidence logic is tried with three kinds of sector vectors. Disjoint vectors, where each side has hits but none in the same sector, separate a same-sector match from a plain OR of the two vectors. A single shared hit in sector 6 exposes off-by-one and bit-order errors. A shared hit whose mask bit is cleared shows that the mask is applied.

Combined codes, a strobe in the same cycle as a write to its entry, and a read in the same cycle as an accept for the same code each test a hazard: entry aliasing, write-before-read ordering and lost counts. Random sparse sector vectors and random reprogramming of the entries then cover the whole decision space against the model in the bench.

// File: rtl/l2ld_pkg.sv
package l2ld_pkg;
   typedef enum logic [1:0] {
      MODE_FAIL  = 2'b00,
      MODE_PASS  = 2'b01,
      MODE_MATCH = 2'b10,
      MODE_RSVD  = 2'b11
   } mode_t;
endpackage

// File: rtl/l2ld_entry_table.sv
module l2ld_entry_table
   import l2ld_pkg::*;
#(
   parameter int CODE_W  = 4,
   parameter int SECTORS = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [CODE_W-1:0]  wr_code,
   input  mode_t              wr_mode,
   input  logic [SECTORS-1:0] wr_mask,
   input  logic [CODE_W-1:0]  rd_code,
   output mode_t              rd_mode,
   output logic [SECTORS-1:0] rd_mask
);
   localparam int ENTRIES = 1 << CODE_W;

   logic [ENTRIES-1:0][1:0]         mode_vec;
   logic [ENTRIES-1:0][SECTORS-1:0] mask_vec;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic [1:0]         mode_q;
      logic [SECTORS-1:0] mask_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q <= MODE_FAIL;
            mask_q <= '0;
         end else if (wr_en && (wr_code == CODE_W'(e))) begin
            mode_q <= wr_mode;
            mask_q <= wr_mask;
         end
      end
      assign mode_vec[e] = mode_q;
      assign mask_vec[e] = mask_q;
   end

   assign rd_mode = mode_t'(mode_vec[rd_code]);
   assign rd_mask = mask_vec[rd_code];
endmodule

// File: rtl/l2ld_match_eval.sv
module l2ld_match_eval
   import l2ld_pkg::*;
#(
   parameter int SECTORS = 6
) (
   input  mode_t              mode,
   input  logic [SECTORS-1:0] mask,
   input  logic [SECTORS-1:0] l1_sec,
   input  logic [SECTORS-1:0] trk_sec,
   output logic               hit
);
   logic [SECTORS-1:0] pair;

   for (genvar s = 0; s < SECTORS; s++) begin : g_sec
      assign pair[s] = l1_sec[s] & trk_sec[s] & mask[s];
   end

   always_comb begin
      unique case (mode)
         MODE_PASS:  hit = 1'b1;
         MODE_MATCH: hit = |pair;
         default:    hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/l2ld_accept_counters.sv
module l2ld_accept_counters #(
   parameter int CODE_W = 4,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic [CODE_W-1:0] inc_code,
   input  logic              rd,
   input  logic [CODE_W-1:0] rd_code,
   output logic [CNT_W-1:0]  rdata
);
   localparam int ENTRIES = 1 << CODE_W;

   logic [ENTRIES-1:0][CNT_W-1:0] cnt_vec;

   for (genvar c = 0; c < ENTRIES; c++) begin : g_cnt
      logic [CNT_W-1:0] cnt_q;
      logic             bump;
      logic             clr;
      assign bump = inc && (inc_code == CODE_W'(c));
      assign clr  = rd && (rd_code == CODE_W'(c));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cnt_q <= '0;
         else if (clr)  cnt_q <= bump ? CNT_W'(1) : '0;
         else if (bump) cnt_q <= cnt_q + CNT_W'(1);
      end
      assign cnt_vec[c] = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= cnt_vec[rd_code];
   end
endmodule

// File: rtl/l2_lookup_decider.sv
module l2_lookup_decider
   import l2ld_pkg::*;
#(
   parameter int CODE_W  = 4,
   parameter int SECTORS = 6,
   parameter int CNT_W   = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [CODE_W-1:0]  in_code,
   input  logic [SECTORS-1:0] in_l1_sec,
   input  logic [SECTORS-1:0] in_trk_sec,
   input  logic               cfg_we,
   input  logic [CODE_W-1:0]  cfg_code,
   input  logic [1:0]         cfg_mode,
   input  logic [SECTORS-1:0] cfg_mask,
   input  logic               cnt_rd,
   input  logic [CODE_W-1:0]  cnt_code,
   output logic [CNT_W-1:0]   cnt_rdata,
   output logic               accept
);
   if (CODE_W < 1 || CODE_W > 6) begin : g_bad_code
      $error("CODE_W must lie in 1..6");
   end
   if (SECTORS < 1 || SECTORS > 32) begin : g_bad_sec
      $error("SECTORS must lie in 1..32");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   mode_t              sel_mode;
   logic [SECTORS-1:0] sel_mask;
   logic               hit;
   logic               take;

   l2ld_entry_table #(.CODE_W(CODE_W), .SECTORS(SECTORS)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_code (cfg_code),
      .wr_mode (mode_t'(cfg_mode)),
      .wr_mask (cfg_mask),
      .rd_code (in_code),
      .rd_mode (sel_mode),
      .rd_mask (sel_mask)
   );

   l2ld_match_eval #(.SECTORS(SECTORS)) u_eval (
      .mode    (sel_mode),
      .mask    (sel_mask),
      .l1_sec  (in_l1_sec),
      .trk_sec (in_trk_sec),
      .hit     (hit)
   );

   assign take = in_valid & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) accept <= 1'b0;
      else        accept <= take;
   end

   l2ld_accept_counters #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (take),
      .inc_code (in_code),
      .rd       (cnt_rd),
      .rd_code  (cnt_code),
      .rdata    (cnt_rdata)
   );
endmodule

// File: rtl/l2_lookup_decider_chk.sv
module l2_lookup_decider_chk
   import l2ld_pkg::*;
#(
   parameter int SECTORS = 6,
   parameter int CNT_W   = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [SECTORS-1:0] in_l1_sec,
   input logic [SECTORS-1:0] in_trk_sec,
   input logic               cnt_rd,
   input logic [CNT_W-1:0]   cnt_rdata,
   input logic               accept,
   input mode_t              sel_mode
);
   // R1: outputs quiet while reset is held
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!accept && cnt_rdata == '0));

   // R4: no accept without a strobe in the previous cycle
   a_r4_accept_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !accept);

   // R2: fail and reserved entries never accept
   a_r2_fail_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (sel_mode == MODE_FAIL || sel_mode == MODE_RSVD)) |=> !accept);

   // R2: pass entries always accept
   a_r2_pass_accepts: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel_mode == MODE_PASS) |=> accept);

   // R3: without a shared sector hit a coincidence entry cannot accept
   a_r3_needs_shared_sector: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel_mode == MODE_MATCH && (in_l1_sec & in_trk_sec) == '0) |=> !accept);

   // R9: read data holds without a read
   a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_rd |=> $stable(cnt_rdata));
endmodule

bind l2_lookup_decider l2_lookup_decider_chk #(.SECTORS(SECTORS), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_l1_sec  (in_l1_sec),
   .in_trk_sec (in_trk_sec),
   .cnt_rd     (cnt_rd),
   .cnt_rdata  (cnt_rdata),
   .accept     (accept),
   .sel_mode   (sel_mode)
);

// File: tb/l2_lookup_decider_tb_top.sv
module l2_lookup_decider_tb_top;
   localparam int CLK_P  = 10;
   localparam int WD_MAX = 100000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid = 1'b0;
   logic [3:0]  in_code = '0;
   logic [5:0]  in_l1_sec = '0;
   logic [5:0]  in_trk_sec = '0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_code = '0;
   logic [1:0]  cfg_mode = '0;
   logic [5:0]  cfg_mask = '0;
   logic        cnt_rd = 1'b0;
   logic [3:0]  cnt_code = '0;
   logic [31:0] cnt_rdata;
   logic        accept;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [1:0]  m_mode [16];
   logic [5:0]  m_mask [16];
   logic [31:0] m_cnt  [16];
   logic [31:0] m_rdata;

   always #(CLK_P/2) clk = ~clk;

   l2_lookup_decider dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
      .in_l1_sec(in_l1_sec), .in_trk_sec(in_trk_sec), .cfg_we(cfg_we),
      .cfg_code(cfg_code), .cfg_mode(cfg_mode), .cfg_mask(cfg_mask),
      .cnt_rd(cnt_rd), .cnt_code(cnt_code), .cnt_rdata(cnt_rdata), .accept(accept)
   );

   function automatic bit f_decide(logic [1:0] m, logic [5:0] k, logic [5:0] a, logic [5:0] b);
      if (m == 2'b01) return 1'b1;
      if (m == 2'b10) return |(k & a & b);
      return 1'b0;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(string tag, bit v, logic [3:0] code, logic [5:0] l1, logic [5:0] trk,
                       bit we, logic [3:0] wc, logic [1:0] wm, logic [5:0] wk,
                       bit rd, logic [3:0] rc);
      bit exp_acc;
      exp_acc = v && f_decide(m_mode[code], m_mask[code], l1, trk);
      if (rd) begin
         m_rdata   = m_cnt[rc];
         m_cnt[rc] = '0;
      end
      if (exp_acc) m_cnt[code] = m_cnt[code] + 1;
      if (we) begin
         m_mode[wc] = wm;
         m_mask[wc] = wk;
      end
      @(negedge clk);
      in_valid = v; in_code = code; in_l1_sec = l1; in_trk_sec = trk;
      cfg_we = we; cfg_code = wc; cfg_mode = wm; cfg_mask = wk;
      cnt_rd = rd; cnt_code = rc;
      @(posedge clk);
      #1;
      chk({tag, " accept"}, {31'd0, accept}, {31'd0, exp_acc});
      chk({tag, " rdata"}, cnt_rdata, m_rdata);
   endtask

   task automatic wr(logic [3:0] c, logic [1:0] m, logic [5:0] k);
      step("R6 write", 0, 4'd0, 6'd0, 6'd0, 1, c, m, k, 0, 4'd0);
   endtask

   task automatic ev(string tag, logic [3:0] c, logic [5:0] a, logic [5:0] b);
      step(tag, 1, c, a, b, 0, 4'd0, 2'b00, 6'd0, 0, 4'd0);
   endtask

   task automatic rdc(string tag, logic [3:0] c);
      step(tag, 0, 4'd0, 6'd0, 6'd0, 0, 4'd0, 2'b00, 6'd0, 1, c);
   endtask

   initial begin : watchdog
      int n = 0;
      while (!done && n < WD_MAX) begin
         @(posedge clk);
         n++;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=finish", n);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd2718));
      for (int i = 0; i < 16; i++) begin
         m_mode[i] = 2'b00; m_mask[i] = '0; m_cnt[i] = '0;
      end
      m_rdata = '0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset accept", {31'd0, accept}, 32'd0);
      chk("R1 reset rdata", cnt_rdata, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: every entry fails after reset, counters zero
      for (int c = 0; c < 16; c++) ev("R1 entry fail", 4'(c), 6'h3F, 6'h3F);
      for (int c = 0; c < 16; c++) rdc("R1 counter zero", 4'(c));

      // R2: pass ignores sectors, reserved and fail do not accept
      wr(4'd5, 2'b01, 6'h00);
      ev("R2 pass empty sectors", 4'd5, 6'h00, 6'h00);
      wr(4'd6, 2'b11, 6'h3F);
      ev("R2 reserved mode", 4'd6, 6'h3F, 6'h3F);
      wr(4'd7, 2'b00, 6'h3F);
      ev("R2 fail mode", 4'd7, 6'h3F, 6'h3F);

      // R3: same-sector match, sector 6 edge, mask exclusion
      wr(4'd1, 2'b10, 6'h3F);
      ev("R3 disjoint sectors", 4'd1, 6'b001000, 6'b000100);
      ev("R3 sector 6 match", 4'd1, 6'b100000, 6'b100000);
      ev("R3 sector 1 match", 4'd1, 6'b000001, 6'b000001);
      wr(4'd1, 2'b10, 6'b011111);
      ev("R3 masked sector 6", 4'd1, 6'b100000, 6'b100000);
      ev("R3 masked other sector", 4'd1, 6'b100010, 6'b100010);

      // R5: combined code 3 has its own entry
      wr(4'd2, 2'b10, 6'h3F);
      ev("R5 code 2 match", 4'd2, 6'h01, 6'h01);
      ev("R5 combined code 3 fails", 4'd3, 6'h01, 6'h01);

      // R6: write and strobe in the same cycle use old contents
      step("R6 same-cycle write", 1, 4'd9, 6'h00, 6'h00, 1, 4'd9, 2'b01, 6'h00, 0, 4'd0);
      ev("R6 after write", 4'd9, 6'h00, 6'h00);

      // R4: no strobe, no accept; back-to-back strobes each pulse
      step("R4 idle pass entry", 0, 4'd5, 6'h3F, 6'h3F, 0, 4'd0, 2'b00, 6'd0, 0, 4'd0);
      ev("R4 back to back a", 4'd5, 6'h00, 6'h00);
      ev("R4 back to back b", 4'd5, 6'h00, 6'h00);
      step("R4 single pulse", 0, 4'd5, 6'h00, 6'h00, 0, 4'd0, 2'b00, 6'd0, 0, 4'd0);

      // R7, R8: read-and-clear, including a same-cycle accept
      rdc("R7 code 5 count", 4'd5);
      step("R8 read with accept", 1, 4'd5, 6'h00, 6'h00, 0, 4'd0, 2'b00, 6'd0, 1, 4'd5);
      rdc("R8 count after race", 4'd5);
      rdc("R8 cleared", 4'd5);

      // R9: read data holds while idle
      repeat (4) step("R9 hold", 0, 4'd0, 6'h00, 6'h00, 0, 4'd0, 2'b00, 6'd0, 0, 4'd0);

      // random phase
      for (int n = 0; n < 5000; n++) begin
         logic [3:0] code;
         logic [5:0] a, b;
         bit we, rd, v;
         code = 4'($urandom_range(0, 15));
         a  = 6'($urandom() & $urandom());
         b  = 6'($urandom() & $urandom());
         v  = ($urandom_range(0, 3) != 0);
         we = ($urandom_range(0, 9) == 0);
         rd = ($urandom_range(0, 7) == 0);
         step("R3 random", v, code, a, b, we, 4'($urandom_range(0, 15)),
              2'($urandom_range(0, 3)), 6'($urandom()), rd, 4'($urandom_range(0, 15)));
      end
      for (int c = 0; c < 16; c++) rdc("R7 final count", 4'(c));

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule